// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage scalar integer pipeline. For each of the two ALU source operands it decides whether the value read from the register file is current, or whether a newer result is still in flight in a later pipeline latch and must be taken from there instead. It compares the two source register numbers of the instruction now in execute against the destination register number of each of the two older instructions ahead of it. A match counts only when that older instruction actually writes a register and its destination is not register zero.

The outputs are two 2-bit select codes, one per operand, that steer the operand multiplexers. Code 2'b00 selects register-file read data. Code 2'b01 selects the result held in the write-back latch. Code 2'b10 selects the result held in the memory-stage latch. When both older instructions target the same source register, the memory-stage copy is the newer one and wins. A producer three instructions ahead has already been written to the register file by the time the consumer reads it, so it needs no bypass. The unit is purely combinational, holds no state and has no clock or reset.

Top module: `opfwd_unit`

## Requirements
- R1: Operand A select is 2'b10 whenever the memory-stage write enable is high, the memory-stage destination is nonzero, and it equals the execute-stage first source number.
- R2: Operand B select is 2'b10 under the same memory-stage conditions, matched against the execute-stage second source number.
- R3: Operand A select is 2'b01 when the write-back write enable is high, the write-back destination is nonzero and equals the first source number, and R1 does not apply.
- R4: Operand B select is 2'b01 when the write-back write enable is high, the write-back destination is nonzero and equals the second source number, and R2 does not apply.
- R5: When both latches match the same source register, that operand's select is 2'b10 (newest producer wins).
- R6: A destination of register zero never produces a nonzero select, whatever the write enables.
- R7: A stage whose write enable is low never produces a select pointing at it, even when its destination number matches.
- R8: With no match, the select is 2'b00; a producer three instructions ahead (already out of both latches) yields 2'b00.
- R9: The selects follow the inputs combinationally, with no clock, and never take the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs_i | input | 5 | First source register number of the instruction in execute |
| id_rt_i | input | 5 | Second source register number of the instruction in execute |
| exm_rd_i | input | 5 | Destination register number held in the memory-stage latch |
| exm_wr_i | input | 1 | Register-write enable held in the memory-stage latch |
| mwb_rd_i | input | 5 | Destination register number held in the write-back latch |
| mwb_wr_i | input | 1 | Register-write enable held in the write-back latch |
| fwd_a_o | output | 2 | Select for operand A: 00 register file, 01 write-back, 10 memory stage |
| fwd_b_o | output | 2 | Select for operand B, same encoding |

## Verification
With no internal state, any fault shows up at the select outputs in the same evaluation as the input pattern that exposes it; nothing can lie hidden for later cycles. A broken comparator or a missing register-zero or write-enable gate shows as a spurious 01 or 10 on exactly the patterns that exercise it, and a swapped priority shows only when both latches name the same register, so those overlapping patterns are driven on purpose. Instruction streams with dependencies one, two and three apart are pushed through a bench-side latch model, so every select value is checked against the distance that produced it.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
    localparam int REG_W   = 5;
    localparam int NUM_SRC = 2;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        FWD_RF = 2'b00,
        FWD_WB = 2'b01,
        FWD_EX = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] rd;
    } producer_t;

    typedef struct packed {
        fwd_sel_e a;
        fwd_sel_e b;
    } fwd_out_t;
endpackage

// File: rtl/opfwd_stage_match.sv
module opfwd_stage_match #(
    parameter int REG_W = 5
) (
    input  logic             wr_i,
    input  logic [REG_W-1:0] rd_i,
    input  logic [REG_W-1:0] src_i,
    output logic             hit_o
);
    logic live_dest;
    logic same_reg;

    always_comb begin
        live_dest = wr_i && (rd_i != '0);
        same_reg  = (rd_i == src_i);
        hit_o     = live_dest && same_reg;
    end
endmodule

// File: rtl/opfwd_prio_sel.sv
module opfwd_prio_sel
    import opfwd_pkg::*;
(
    input  logic     ex_hit_i,
    input  logic     wb_hit_i,
    output fwd_sel_e sel_o
);
    always_comb begin
        if (ex_hit_i) begin
            sel_o = FWD_EX;
        end else if (wb_hit_i) begin
            sel_o = FWD_WB;
        end else begin
            sel_o = FWD_RF;
        end
    end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
(
    input  logic [4:0] id_rs_i,
    input  logic [4:0] id_rt_i,
    input  logic [4:0] exm_rd_i,
    input  logic       exm_wr_i,
    input  logic [4:0] mwb_rd_i,
    input  logic       mwb_wr_i,
    output logic [1:0] fwd_a_o,
    output logic [1:0] fwd_b_o
);
    producer_t            exm_prod;
    producer_t            mwb_prod;
    logic [REG_W-1:0]     src_num [NUM_SRC];
    logic [NUM_SRC-1:0]   ex_hit;
    logic [NUM_SRC-1:0]   wb_hit;
    fwd_sel_e             sel_d   [NUM_SRC];
    fwd_out_t             out_d;

    always_comb begin
        exm_prod.wr = exm_wr_i;
        exm_prod.rd = exm_rd_i;
        mwb_prod.wr = mwb_wr_i;
        mwb_prod.rd = mwb_rd_i;
        src_num[0]  = id_rs_i;
        src_num[1]  = id_rt_i;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        opfwd_stage_match #(.REG_W(REG_W)) u_ex_match (
            .wr_i  (exm_prod.wr),
            .rd_i  (exm_prod.rd),
            .src_i (src_num[s]),
            .hit_o (ex_hit[s])
        );
        opfwd_stage_match #(.REG_W(REG_W)) u_wb_match (
            .wr_i  (mwb_prod.wr),
            .rd_i  (mwb_prod.rd),
            .src_i (src_num[s]),
            .hit_o (wb_hit[s])
        );
        opfwd_prio_sel u_prio (
            .ex_hit_i (ex_hit[s]),
            .wb_hit_i (wb_hit[s]),
            .sel_o    (sel_d[s])
        );
    end

    always_comb begin
        out_d.a = sel_d[0];
        out_d.b = sel_d[1];
        fwd_a_o = out_d.a;
        fwd_b_o = out_d.b;
    end
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk (
    input logic [4:0] id_rs_i,
    input logic [4:0] id_rt_i,
    input logic [4:0] exm_rd_i,
    input logic       exm_wr_i,
    input logic [4:0] mwb_rd_i,
    input logic       mwb_wr_i,
    input logic [1:0] fwd_a_o,
    input logic [1:0] fwd_b_o
);
    always_comb begin
        if (exm_wr_i && exm_rd_i != 5'd0 && exm_rd_i == id_rs_i)
            AST_EX_OPA: assert (fwd_a_o == 2'b10) else $error("ex bypass A"); // R1
        if (exm_wr_i && exm_rd_i != 5'd0 && exm_rd_i == id_rt_i)
            AST_EX_OPB: assert (fwd_b_o == 2'b10) else $error("ex bypass B"); // R2
        if (fwd_a_o == 2'b01)
            AST_WB_OPA: assert (mwb_wr_i && mwb_rd_i == id_rs_i) else $error("wb select A"); // R3
        if (fwd_b_o == 2'b01)
            AST_WB_OPB: assert (mwb_wr_i && mwb_rd_i == id_rt_i) else $error("wb select B"); // R4
        if (id_rs_i == 5'd0)
            AST_ZERO_SRC_A: assert (fwd_a_o == 2'b00) else $error("zero reg A"); // R6
        if (id_rt_i == 5'd0)
            AST_ZERO_SRC_B: assert (fwd_b_o == 2'b00) else $error("zero reg B"); // R6
        if (!exm_wr_i && !mwb_wr_i)
            AST_NO_WRITERS: assert (fwd_a_o == 2'b00 && fwd_b_o == 2'b00) else $error("no writer"); // R7
        AST_NO_CODE3: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11) else $error("code 11"); // R9
    end
endmodule

bind opfwd_unit opfwd_unit_chk u_opfwd_unit_chk (
    .id_rs_i  (id_rs_i),
    .id_rt_i  (id_rt_i),
    .exm_rd_i (exm_rd_i),
    .exm_wr_i (exm_wr_i),
    .mwb_rd_i (mwb_rd_i),
    .mwb_wr_i (mwb_wr_i),
    .fwd_a_o  (fwd_a_o),
    .fwd_b_o  (fwd_b_o)
);

// File: tb/opfwd_unit_bench.sv
module opfwd_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] id_rs, id_rt, exm_rd, mwb_rd;
    logic       exm_wr, mwb_wr;
    logic [1:0] fwd_a, fwd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    // bench-side latch model: [0]=memory stage, [1]=write-back stage
    logic [4:0] pipe_rd [2];
    logic       pipe_wr [2];

    always #10 clk = ~clk;

    opfwd_unit u_opfwd_unit (
        .id_rs_i  (id_rs),
        .id_rt_i  (id_rt),
        .exm_rd_i (exm_rd),
        .exm_wr_i (exm_wr),
        .mwb_rd_i (mwb_rd),
        .mwb_wr_i (mwb_wr),
        .fwd_a_o  (fwd_a),
        .fwd_b_o  (fwd_b)
    );

    function automatic logic [1:0] ref_sel(input logic [4:0] src,
                                           input logic ew, input logic [4:0] er,
                                           input logic ww, input logic [4:0] wr);
        logic [1:0] r;
        r = 2'b00;
        if (ww && wr != 5'd0 && wr == src) r = 2'b01;
        if (ew && er != 5'd0 && er == src) r = 2'b10;
        return r;
    endfunction

    task automatic apply(input logic [4:0] rs, input logic [4:0] rt,
                         input logic ew, input logic [4:0] er,
                         input logic ww, input logic [4:0] wr, input string tag);
        exp_t e;
        @(posedge clk);
        id_rs = rs; id_rt = rt; exm_wr = ew; exm_rd = er; mwb_wr = ww; mwb_rd = wr;
        e.a = ref_sel(rs, ew, er, ww, wr);
        e.b = ref_sel(rt, ew, er, ww, wr);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // issue one instruction into execute; older ones shift into the latches
    task automatic issue(input logic [4:0] rs, input logic [4:0] rt,
                         input logic wr, input logic [4:0] rd, input string tag);
        apply(rs, rt, pipe_wr[0], pipe_rd[0], pipe_wr[1], pipe_rd[1], tag);
        pipe_wr[1] = pipe_wr[0]; pipe_rd[1] = pipe_rd[0];
        pipe_wr[0] = wr;         pipe_rd[0] = rd;
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (fwd_a !== e.a || fwd_b !== e.b) begin
                errors++;
                $display("FAIL %s a=%b b=%b expected a=%b b=%b", e.tag, fwd_a, fwd_b, e.a, e.b);
            end
        end
    end

    initial begin
        id_rs = '0; id_rt = '0; exm_rd = '0; mwb_rd = '0; exm_wr = 0; mwb_wr = 0;
        pipe_rd[0] = '0; pipe_rd[1] = '0; pipe_wr[0] = 0; pipe_wr[1] = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        apply(5'd0, 5'd0, 0, 5'd0, 0, 5'd0, "R8 idle");
        apply(5'd3, 5'd9, 1, 5'd3, 0, 5'd0, "R1 ex A");
        apply(5'd4, 5'd7, 1, 5'd7, 0, 5'd0, "R2 ex B");
        apply(5'd6, 5'd1, 0, 5'd0, 1, 5'd6, "R3 wb A");
        apply(5'd2, 5'd11, 1, 5'd20, 1, 5'd11, "R4 wb B");
        apply(5'd8, 5'd8, 1, 5'd8, 1, 5'd8, "R5 both match");
        apply(5'd5, 5'd12, 1, 5'd12, 1, 5'd5, "R5 split");
        apply(5'd0, 5'd0, 1, 5'd0, 1, 5'd0, "R6 zero dest");
        apply(5'd0, 5'd3, 1, 5'd0, 1, 5'd3, "R6 zero A");
        apply(5'd14, 5'd14, 0, 5'd14, 0, 5'd14, "R7 wr low");
        apply(5'd14, 5'd15, 0, 5'd14, 1, 5'd14, "R7 ex off wb on");
        apply(5'd21, 5'd22, 1, 5'd23, 1, 5'd24, "R8 no match");
        // sequence: producer r2 then consumers at distance 1,2,3
        issue(5'd1, 5'd3, 1, 5'd2, "R8 seq producer");
        issue(5'd2, 5'd5, 1, 5'd12, "R1 seq dist1");
        issue(5'd6, 5'd2, 1, 5'd13, "R4 seq dist2");
        issue(5'd2, 5'd2, 1, 5'd14, "R8 seq dist3");
        // branch-like non-writer followed by consumer
        issue(5'd14, 5'd0, 0, 5'd14, "R1 seq after");
        issue(5'd14, 5'd13, 1, 5'd9, "R7 seq nonwriter");
        // R9: sweep, outputs always valid codes
        for (int i = 0; i < 300; i++) begin
            apply(5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), 5'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), 5'($urandom_range(0, 7)), "R9 sweep");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule